// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block owns the row and column strobes of an EDO DRAM whenever no access is in progress, and keeps the array refreshed. Out of reset it idles the strobes for a programmable pause. It then runs a fixed burst of CAS-before-RAS refresh cycles and raises a done flag. From then on a free-running interval timer schedules one CAS-before-RAS refresh per interval. The interval is chosen so that every row is visited inside the retention period.

An access controller shares the strobes through a request/grant pair. While the access side holds the grant, due refreshes are counted up to a saturating limit. They run back to back as soon as the grant is returned. A level command puts the memory into self refresh. A full refresh pass runs first, then CAS and RAS are held low for at least a minimum time. Another full pass follows the exit precharge. All durations are parameters in clock cycles.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: While reset is asserted, rasN and casN are high and memGnt, initDone and selfRefActive are low.
- R2: The first refresh begins PAUSE_CYC cycles after reset release. INIT_REFS refreshes then follow back to back. In each refresh, casN is low alone for LEAD_CYC cycles, then both strobes are low for RASLO_CYC cycles, then both are high for PRECH_CYC cycles.
- R3: initDone rises in the cycle after the precharge of the last power-up refresh completes, and it stays high.
- R4: No grant is given before initDone. In the idle state, memGnt rises one cycle after memReq is seen high. It falls one cycle after memReq is seen low.
- R5: A refresh becomes due every INTERVAL_CYC cycles, counted from the end of the last full refresh pass. casN falls one cycle after the refresh becomes due, so the first periodic refresh starts INTERVAL_CYC+1 cycles after initDone rises.
- R6: Refreshes that fall due while the grant is held are counted, saturating at PEND_MAX. They run back to back with the first casN fall two cycles after memReq drops, and any excess is dropped.
- R7: memGnt is never high while rasN or casN is low. A request that arrives during a refresh is granted one cycle after that refresh's precharge ends.
- R8: When selfReq is high in the idle state, ROWS refreshes run back to back. casN then falls, rasN falls LEAD_CYC cycles later, and selfRefActive is high exactly while rasN is held low.
- R9: In self refresh, rasN stays low for at least SELFMIN_CYC cycles and until selfReq is seen low. It rises in the first cycle where both conditions hold.
- R10: After self refresh, both strobes stay high for SELFRP_CYC cycles. Then ROWS refreshes run back to back, and the interval timer restarts when that pass ends.
- R11: rasN never falls unless casN was already low in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| memReq | input | 1 | Access side asks for the strobes |
| selfReq | input | 1 | Level command: high enters and holds self refresh |
| memGnt | output | 1 | Access side owns the strobes |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe (both bytes), active low |
| initDone | output | 1 | Power-up sequence complete |
| selfRefActive | output | 1 | Memory is held in self refresh |

## Verification
Every strobe change follows the state register, so it appears one clock edge after the condition that causes it. This holds for a due tick, a request, the end of a phase, or the drop of a self-refresh command. Grant changes also take one edge. The first refresh after a released grant starts two edges after the release, and the first periodic refresh starts INTERVAL_CYC+1 edges after initDone. The stimulus runs against a cycle counter, and the expected start, lead and low length of every strobe pulse are queued in advance. The monitor samples at the falling clock edge, measures each pulse as it completes, and compares it with the head of the queue. Directed grant, done and self-refresh flag checks are placed on the exact cycle either side of each due change.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

  typedef enum logic [2:0] {
    PH_PAUSE, PH_LEAD, PH_RASLO, PH_PRECH, PH_SELFMIN, PH_SELFRP
  } phaseSel_e;

  typedef enum logic [1:0] {
    BK_INIT, BK_PERIODIC, BK_ENTRY, BK_EXIT
  } burstKind_e;

  typedef enum logic [3:0] {
    ST_PAUSE, ST_IDLE, ST_GRANT, ST_LEAD, ST_RASLO, ST_PRECH,
    ST_SLEAD, ST_SHOLD, ST_SRP
  } ctlState_e;

  // control -> datapath
  typedef struct packed {
    logic      phaseLoad;
    phaseSel_e phaseSel;
    logic      tmrRestart;
    logic      pendDec;
    logic      burstLoad;
    logic      burstInit;
    logic      burstDec;
  } refStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic phaseDone;
    logic pendAny;
    logic burstLast;
  } refStatus_t;

endpackage

// File: rtl/refresh_datapath.sv
module refresh_datapath
  import dram_refresh_pkg::*;
#(
  parameter int PAUSE_CYC    = 20000,
  parameter int INIT_REFS    = 8,
  parameter int LEAD_CYC     = 1,
  parameter int RASLO_CYC    = 5,
  parameter int PRECH_CYC    = 4,
  parameter int INTERVAL_CYC = 1560,
  parameter int PEND_MAX     = 7,
  parameter int SELFMIN_CYC  = 10000,
  parameter int SELFRP_CYC   = 11000,
  parameter int ROWS         = 4096
) (
  input  logic       clk,
  input  logic       rstN,
  input  refStrobe_t strb,
  output refStatus_t stat
);

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int PH_MAX = maxOf(maxOf(maxOf(PAUSE_CYC, LEAD_CYC), maxOf(RASLO_CYC, PRECH_CYC)),
                                maxOf(SELFMIN_CYC, SELFRP_CYC));
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int IV_W   = $clog2(INTERVAL_CYC + 1);
  localparam int PD_W   = $clog2(PEND_MAX + 1);
  localparam int BC_W   = $clog2(maxOf(ROWS, INIT_REFS) + 1);

  // phase timer: a state of length D loads D-1 and ends when it reads zero
  logic [PH_W-1:0] phaseCnt;
  logic [PH_W-1:0] phaseLoadVal;

  always_comb begin
    unique case (strb.phaseSel)
      PH_PAUSE:   phaseLoadVal = PH_W'(PAUSE_CYC - 1);
      PH_LEAD:    phaseLoadVal = PH_W'(LEAD_CYC - 1);
      PH_RASLO:   phaseLoadVal = PH_W'(RASLO_CYC - 1);
      PH_PRECH:   phaseLoadVal = PH_W'(PRECH_CYC - 1);
      PH_SELFMIN: phaseLoadVal = PH_W'(SELFMIN_CYC - 1);
      PH_SELFRP:  phaseLoadVal = PH_W'(SELFRP_CYC - 1);
      default:    phaseLoadVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  phaseCnt <= PH_W'(PAUSE_CYC - 1);
    else if (strb.phaseLoad)    phaseCnt <= phaseLoadVal;
    else if (phaseCnt != '0)    phaseCnt <= phaseCnt - PH_W'(1);
  end

  // free-running interval timer
  logic [IV_W-1:0] ivCnt;
  logic            tick;
  assign tick = (ivCnt == IV_W'(INTERVAL_CYC - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                ivCnt <= '0;
    else if (strb.tmrRestart) ivCnt <= '0;
    else if (tick)            ivCnt <= '0;
    else                      ivCnt <= ivCnt + IV_W'(1);
  end

  // pending refresh counter, saturating
  logic [PD_W-1:0] pendCnt;
  logic            incOk;
  assign incOk = tick && (strb.pendDec || (pendCnt != PD_W'(PEND_MAX)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                pendCnt <= '0;
    else if (strb.tmrRestart) pendCnt <= '0;
    else begin
      unique case ({incOk, strb.pendDec})
        2'b10:   pendCnt <= pendCnt + PD_W'(1);
        2'b01:   pendCnt <= pendCnt - PD_W'(1);
        default: pendCnt <= pendCnt;
      endcase
    end
  end

  // burst counter: remaining refreshes after the current one
  logic [BC_W-1:0] burstCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               burstCnt <= '0;
    else if (strb.burstLoad) burstCnt <= strb.burstInit ? BC_W'(INIT_REFS - 1) : BC_W'(ROWS - 1);
    else if (strb.burstDec)  burstCnt <= burstCnt - BC_W'(1);
  end

  assign stat.phaseDone = (phaseCnt == '0);
  assign stat.pendAny   = (pendCnt != '0);
  assign stat.burstLast = (burstCnt == '0);

  p_pend_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    pendCnt <= PD_W'(PEND_MAX));

  p_dec_has_pend_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.pendDec |-> (pendCnt != '0));

  p_burst_dec_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.burstDec |-> (burstCnt != '0));

endmodule

// File: rtl/refresh_control.sv
module refresh_control
  import dram_refresh_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       memReq,
  input  logic       selfReq,
  input  refStatus_t stat,
  output refStrobe_t strb,
  output logic       rasN,
  output logic       casN,
  output logic       memGnt,
  output logic       initDone,
  output logic       selfRefActive
);

  ctlState_e  state, nextState;
  burstKind_e kind, nextKind;
  logic       initDoneQ, setInit;

  always_comb begin
    nextState = state;
    nextKind  = kind;
    strb      = '0;
    setInit   = 1'b0;
    unique case (state)
      ST_PAUSE: if (stat.phaseDone) begin
        nextState      = ST_LEAD;
        strb.phaseLoad = 1'b1;
        strb.phaseSel  = PH_LEAD;
        strb.burstLoad = 1'b1;
        strb.burstInit = 1'b1;
        nextKind       = BK_INIT;
      end
      ST_IDLE: begin
        if (stat.pendAny) begin
          nextState      = ST_LEAD;
          strb.phaseLoad = 1'b1;
          strb.phaseSel  = PH_LEAD;
          strb.pendDec   = 1'b1;
          nextKind       = BK_PERIODIC;
        end else if (selfReq) begin
          nextState      = ST_LEAD;
          strb.phaseLoad = 1'b1;
          strb.phaseSel  = PH_LEAD;
          strb.burstLoad = 1'b1;
          nextKind       = BK_ENTRY;
        end else if (memReq) begin
          nextState = ST_GRANT;
        end
      end
      ST_GRANT: if (!memReq) nextState = ST_IDLE;
      ST_LEAD: if (stat.phaseDone) begin
        nextState      = ST_RASLO;
        strb.phaseLoad = 1'b1;
        strb.phaseSel  = PH_RASLO;
      end
      ST_RASLO: if (stat.phaseDone) begin
        nextState      = ST_PRECH;
        strb.phaseLoad = 1'b1;
        strb.phaseSel  = PH_PRECH;
      end
      ST_PRECH: if (stat.phaseDone) begin
        if (kind == BK_PERIODIC) begin
          if (stat.pendAny) begin
            nextState      = ST_LEAD;
            strb.phaseLoad = 1'b1;
            strb.phaseSel  = PH_LEAD;
            strb.pendDec   = 1'b1;
          end else begin
            nextState = ST_IDLE;
          end
        end else if (!stat.burstLast) begin
          nextState      = ST_LEAD;
          strb.phaseLoad = 1'b1;
          strb.phaseSel  = PH_LEAD;
          strb.burstDec  = 1'b1;
        end else if (kind == BK_ENTRY) begin
          nextState      = ST_SLEAD;
          strb.phaseLoad = 1'b1;
          strb.phaseSel  = PH_LEAD;
        end else begin
          nextState       = ST_IDLE;
          strb.tmrRestart = 1'b1;
          setInit         = (kind == BK_INIT);
        end
      end
      ST_SLEAD: if (stat.phaseDone) begin
        nextState      = ST_SHOLD;
        strb.phaseLoad = 1'b1;
        strb.phaseSel  = PH_SELFMIN;
      end
      ST_SHOLD: if (stat.phaseDone && !selfReq) begin
        nextState      = ST_SRP;
        strb.phaseLoad = 1'b1;
        strb.phaseSel  = PH_SELFRP;
      end
      ST_SRP: if (stat.phaseDone) begin
        nextState      = ST_LEAD;
        strb.phaseLoad = 1'b1;
        strb.phaseSel  = PH_LEAD;
        strb.burstLoad = 1'b1;
        nextKind       = BK_EXIT;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_PAUSE;
      kind      <= BK_INIT;
      initDoneQ <= 1'b0;
    end else begin
      state <= nextState;
      kind  <= nextKind;
      if (setInit) initDoneQ <= 1'b1;
    end
  end

  assign rasN          = !(state inside {ST_RASLO, ST_SHOLD});
  assign casN          = !(state inside {ST_LEAD, ST_RASLO, ST_SLEAD, ST_SHOLD});
  assign memGnt        = (state == ST_GRANT);
  assign selfRefActive = (state == ST_SHOLD);
  assign initDone      = initDoneQ;

  p_cbr_order_r11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> (!casN && $past(!casN)));

  p_gnt_bus_free_r7: assert property (@(posedge clk) disable iff (!rstN)
    memGnt |-> (rasN && casN));

  p_gnt_after_init_r4: assert property (@(posedge clk) disable iff (!rstN)
    memGnt |-> initDone);

  p_init_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

  p_self_exit_cmd_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(selfRefActive) |-> $past(!selfReq));

  p_self_lead_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(selfRefActive) |-> $past(!casN));

endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
  import dram_refresh_pkg::*;
#(
  parameter int PAUSE_CYC    = 20000,
  parameter int INIT_REFS    = 8,
  parameter int LEAD_CYC     = 1,
  parameter int RASLO_CYC    = 5,
  parameter int PRECH_CYC    = 4,
  parameter int INTERVAL_CYC = 1560,
  parameter int PEND_MAX     = 7,
  parameter int SELFMIN_CYC  = 10000,
  parameter int SELFRP_CYC   = 11000,
  parameter int ROWS         = 4096
) (
  input  logic clk,
  input  logic rstN,
  input  logic memReq,
  input  logic selfReq,
  output logic memGnt,
  output logic rasN,
  output logic casN,
  output logic initDone,
  output logic selfRefActive
);

  refStrobe_t strb;
  refStatus_t stat;

  refresh_control u_ctl (
    .clk(clk), .rstN(rstN), .memReq(memReq), .selfReq(selfReq),
    .stat(stat), .strb(strb), .rasN(rasN), .casN(casN),
    .memGnt(memGnt), .initDone(initDone), .selfRefActive(selfRefActive)
  );

  refresh_datapath #(
    .PAUSE_CYC(PAUSE_CYC), .INIT_REFS(INIT_REFS), .LEAD_CYC(LEAD_CYC),
    .RASLO_CYC(RASLO_CYC), .PRECH_CYC(PRECH_CYC), .INTERVAL_CYC(INTERVAL_CYC),
    .PEND_MAX(PEND_MAX), .SELFMIN_CYC(SELFMIN_CYC), .SELFRP_CYC(SELFRP_CYC),
    .ROWS(ROWS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .stat(stat)
  );

endmodule

// File: tb/test_dram_refresh_ctrl.sv
module test_dram_refresh_ctrl;

  localparam int PAUSE = 50, INITN = 8, LEAD = 2, RASLO = 4, PRECH = 3;
  localparam int INTV = 40, PMAX = 3, SMIN = 30, SRP = 20, ROWS = 8;
  localparam int REF = LEAD + RASLO + PRECH;
  localparam int E = PAUSE + INITN * REF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic memReq = 1'b0;
  logic selfReq = 1'b0;
  logic memGnt, rasN, casN, initDone, selfRefActive;

  always #2 clk = ~clk;

  dram_refresh_ctrl #(
    .PAUSE_CYC(PAUSE), .INIT_REFS(INITN), .LEAD_CYC(LEAD), .RASLO_CYC(RASLO),
    .PRECH_CYC(PRECH), .INTERVAL_CYC(INTV), .PEND_MAX(PMAX), .SELFMIN_CYC(SMIN),
    .SELFRP_CYC(SRP), .ROWS(ROWS)
  ) i_dram_refresh_ctrl (
    .clk(clk), .rstN(rstN), .memReq(memReq), .selfReq(selfReq), .memGnt(memGnt),
    .rasN(rasN), .casN(casN), .initDone(initDone), .selfRefActive(selfRefActive)
  );

  int cyc = 0;
  always @(posedge clk) begin
    if (!rstN) cyc <= 0;
    else       cyc <= cyc + 1;
  end

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  typedef struct {
    int    start;
    int    lead;
    int    low;
    string tag;
  } pulse_t;

  pulse_t q[$];

  task automatic pushPulse(input int start, input int low, input string tag);
    pulse_t p;
    p.start = start; p.lead = LEAD; p.low = low; p.tag = tag;
    q.push_back(p);
  endtask

  task automatic pushBurst(input int start, input int n, input string tag);
    for (int i = 0; i < n; i++) pushPulse(start + i * REF, RASLO, tag);
  endtask

  task automatic waitTo(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // monitor: measures each strobe pulse and compares with the queue head
  logic prevRas = 1'b1, prevCas = 1'b1;
  int casFall = 0, rasFall = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (prevCas && !casN) casFall = cyc;
      if (prevRas && !rasN) rasFall = cyc;
      if (!prevRas && rasN) begin
        if (q.size() == 0) begin
          chk("unexpected pulse", casFall, -1);
        end else begin
          pulse_t p;
          p = q.pop_front();
          chk({p.tag, " start"}, casFall, p.start);
          chk("R11 cas lead", rasFall - casFall, p.lead);
          chk({p.tag, " ras low"}, cyc - rasFall, p.low);
        end
      end
    end
    prevRas = rasN;
    prevCas = casN;
  end

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog: actual running expected finished");
    finishRun();
  end

  initial begin
    int D, P6, S0, L, X, E2, S1, L2, X2, F;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rasN", rasN, 1);
    chk("R1 casN", casN, 1);
    chk("R1 memGnt", memGnt, 0);
    chk("R1 initDone", initDone, 0);
    chk("R1 selfRefActive", selfRefActive, 0);
    rstN = 1'b1;
    pushBurst(PAUSE, INITN, "R2 init");

    // R4 request during power-up is not granted
    waitTo(10); memReq = 1'b1;
    waitTo(E - 1);
    chk("R4 no grant before init", memGnt, 0);
    chk("R3 initDone before", initDone, 0);
    memReq = 1'b0;
    waitTo(E);
    chk("R3 initDone rises", initDone, 1);
    chk("R4 no grant at init", memGnt, 0);

    // R5 first periodic refresh
    pushPulse(E + INTV + 1, RASLO, "R5 periodic");

    // R4 grant, R6 pending saturation
    waitTo(E + INTV + 15);
    memReq = 1'b1;
    chk("R4 grant not yet", memGnt, 0);
    waitTo(E + INTV + 16);
    chk("R4 grant one cycle", memGnt, 1);
    D = E + 5 * INTV + 1;
    waitTo(D);
    chk("R3 initDone held", initDone, 1);
    memReq = 1'b0;
    pushBurst(D + 2, PMAX, "R6 pending");
    waitTo(D + 1);
    chk("R4 grant released", memGnt, 0);

    // R7 request during a refresh
    P6 = E + 6 * INTV + 1;
    pushPulse(P6, RASLO, "R5 periodic");
    waitTo(P6);
    memReq = 1'b1;
    waitTo(P6 + REF);
    chk("R7 no grant during refresh", memGnt, 0);
    waitTo(P6 + REF + 1);
    chk("R7 grant after precharge", memGnt, 1);
    waitTo(P6 + REF + 3);
    memReq = 1'b0;

    // R8/R9/R10 self refresh held past minimum
    S0 = P6 + REF + 8;
    waitTo(S0);
    selfReq = 1'b1;
    pushBurst(S0 + 1, ROWS, "R8 entry pass");
    L = S0 + 1 + ROWS * REF;
    pushPulse(L, 41, "R9 self hold");
    X = L + LEAD + 41 + SRP;
    pushBurst(X, ROWS, "R10 exit pass");
    E2 = X + ROWS * REF;
    pushPulse(E2 + INTV + 1, RASLO, "R10 timer restart");
    waitTo(L + LEAD - 1);
    chk("R8 self flag before ras", selfRefActive, 0);
    waitTo(L + LEAD);
    chk("R8 self flag", selfRefActive, 1);
    waitTo(L + LEAD + 40);
    selfReq = 1'b0;
    chk("R9 self still held", selfRefActive, 1);
    waitTo(L + LEAD + 41);
    chk("R9 self released", selfRefActive, 0);

    // R9 short command: held exactly the minimum
    S1 = E2 + INTV + 1 + REF + 5;
    waitTo(S1);
    selfReq = 1'b1;
    pushBurst(S1 + 1, ROWS, "R8 entry pass");
    L2 = S1 + 1 + ROWS * REF;
    pushPulse(L2, SMIN, "R9 self minimum");
    X2 = L2 + LEAD + SMIN + SRP;
    pushBurst(X2, ROWS, "R10 exit pass");
    F = X2 + ROWS * REF;
    waitTo(L2 + LEAD + 3);
    selfReq = 1'b0;
    waitTo(L2 + LEAD + SMIN - 1);
    chk("R9 minimum hold", selfRefActive, 1);
    waitTo(L2 + LEAD + SMIN);
    chk("R9 minimum end", selfRefActive, 0);

    waitTo(F + 5);
    chk("R10 all pulses seen", q.size(), 0);
    chk("R10 idle rasN", rasN, 1);
    chk("R10 idle casN", casN, 1);
    chk("R3 initDone final", initDone, 1);
    finishRun();
  end

endmodule